// File: doc/BRIEF.md
# Time-Target Periodic Pulse Generator

This block turns an absolute time-of-day value into scheduled output pulses. A free-running local clock, made of a 32-bit seconds count and a 30-bit nanoseconds count, comes in on input ports. The block provides two independent channels, and each one compares that time against its own programmed target. When the time reaches the target, the channel drives a pulse whose width is selected by a 4-bit logarithmic code and whose polarity can be set. The channel then either moves its target forward by a reload period, which gives a periodic train, or disarms itself, which gives a single pulse.

Software programs the block through a 16-bit synchronous write/read port. Each channel has an eight-word address block that holds a staged target time and a reload period. One shared word holds the width codes, the polarities and the one-shot controls. A staged target becomes live only when its nanoseconds-high word is written. This lets software move a running channel to a new start time, for example a few seconds after a time step, without any risk of a match on a half-written value.

Top module: `tod_pulse_gen`

## Requirements
- R1: After reset every channel is disarmed, every register reads zero, and each output sits at its idle level, which is the inverse of its polarity bit (so both outputs are 1 after reset).
- R2: Registers read back one clock after the address is presented. Channel c occupies addresses 8c..8c+7, in this order: target seconds high, target seconds low, target nanoseconds high, target nanoseconds low, period seconds high, period seconds low, period nanoseconds high, period nanoseconds low. The shared configuration word sits at address 16. Bits 15:14 of either nanoseconds-high word and bits 15:12 of the configuration word are not stored and read as 0.
- R3: Writes to target seconds high, target seconds low and target nanoseconds low are only staged. Writing the target nanoseconds-high word (offset 2) loads the full staged target and arms the channel. A partial write never causes a match.
- R4: An armed channel matches at the first clock edge at which the sampled {seconds, nanoseconds} is greater than or equal to its target. Its output turns active right after that edge.
- R5: The pulse ends at the first edge at which the time is at or past the target plus the width. Width codes 0..13 select 100 ns, 500 ns, 1 us, 5 us, 10 us, 50 us, 100 us, 500 us, 1 ms, 5 ms, 10 ms, 50 ms, 100 ms and 200 ms. Codes 14 and 15 select 100 ns. Nanoseconds carry into seconds at 10^9.
- R6: A polarity bit of 1 makes the active level 1. A polarity bit of 0 makes the active level 0.
- R7: With the one-shot bit clear, every match adds the period to the target, with a nanoseconds carry into seconds at 10^9, so the pulse repeats once per period.
- R8: With the one-shot bit set, a match disarms the channel. It does not fire again until a new target is loaded.
- R9: A target of 0xFFFFFFFF seconds is never reached by a smaller time, so it holds the channel silent.
- R10: Configuration layout, which separates the channels: bit 0 is the channel 0 one-shot bit, bit 1 the channel 0 polarity, bit 2 the channel 1 one-shot bit, bit 3 the channel 1 polarity, bits 7:4 the channel 0 width code and bits 11:8 the channel 1 width code. Activity on one channel leaves the other output unchanged.
- R11: Loading a new target while armed replaces any pending target, including one produced by a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tod_sec | input | 32 | Local time, seconds part |
| tod_ns | input | 30 | Local time, nanoseconds part (below 10^9) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for write and read |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Read data for the address of the previous cycle |
| pulse_out | output | 2 | Channel outputs, bit c for channel c |

## Verification
The bench builds the block with its default parameters: two channels, a 5-bit address and 16-bit data. Because the time of day is an input, the bench jumps it straight to the instants that matter: just before and exactly at a target, one nanosecond before a pulse ends, and across a nanosecond rollover. This brings the 200 ms width code, carries into seconds and the never-reached all-ones seconds target within reach in a few cycles. A vector table walks every width code. Directed cases then cover readback masking, staged-then-committed targets, periodic reload with a carry, and a target being replaced.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int SEC_W      = 32;
    localparam int NS_W       = 30;
    localparam int WCODE_W    = 4;
    localparam int NS_PER_SEC = 1_000_000_000;

    // seconds in the upper field so a packed compare orders whole times
    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;

    // logarithmic pulse width code to nanoseconds
    function automatic logic [NS_W-1:0] width_ns(input logic [WCODE_W-1:0] code);
        logic [NS_W-1:0] w;
        case (code)
            4'd0:    w = NS_W'(100);
            4'd1:    w = NS_W'(500);
            4'd2:    w = NS_W'(1_000);
            4'd3:    w = NS_W'(5_000);
            4'd4:    w = NS_W'(10_000);
            4'd5:    w = NS_W'(50_000);
            4'd6:    w = NS_W'(100_000);
            4'd7:    w = NS_W'(500_000);
            4'd8:    w = NS_W'(1_000_000);
            4'd9:    w = NS_W'(5_000_000);
            4'd10:   w = NS_W'(10_000_000);
            4'd11:   w = NS_W'(50_000_000);
            4'd12:   w = NS_W'(100_000_000);
            4'd13:   w = NS_W'(200_000_000);
            default: w = NS_W'(100);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/tpg_time_add.sv
module tpg_time_add
    import tpg_pkg::*;
(
    input  tod_t a,
    input  tod_t b,
    output tod_t sum
);
    localparam logic [NS_W:0] NSPS = (NS_W+1)'(NS_PER_SEC);

    logic [NS_W:0] ns_raw;
    logic          carry;

    always_comb begin
        ns_raw  = {1'b0, a.ns} + {1'b0, b.ns};
        carry   = (ns_raw >= NSPS);
        sum.ns  = carry ? NS_W'(ns_raw - NSPS) : ns_raw[NS_W-1:0];
        sum.sec = a.sec + b.sec + SEC_W'(carry);
    end
endmodule

// File: rtl/tpg_regs.sv
module tpg_regs
    import tpg_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic [NUM_CH-1:0]              ld_stb,
    output tod_t [NUM_CH-1:0]              ld_tgt,
    output tod_t [NUM_CH-1:0]              period,
    output logic [NUM_CH-1:0][WCODE_W-1:0] wcode,
    output logic [NUM_CH-1:0]              pol,
    output logic [NUM_CH-1:0]              oneshot
);
    localparam int BLK_W = ADDR_W - 3;
    localparam int NSH_W = NS_W - DATA_W;
    localparam int CFG_W = 2*NUM_CH + WCODE_W*NUM_CH;
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(NUM_CH*8);

    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] t_sh;
        logic [NUM_CH-1:0][DATA_W-1:0] t_sl;
        logic [NUM_CH-1:0][NSH_W-1:0]  t_nh;
        logic [NUM_CH-1:0][DATA_W-1:0] t_nl;
        logic [NUM_CH-1:0][DATA_W-1:0] p_sh;
        logic [NUM_CH-1:0][DATA_W-1:0] p_sl;
        logic [NUM_CH-1:0][NSH_W-1:0]  p_nh;
        logic [NUM_CH-1:0][DATA_W-1:0] p_nl;
        logic [CFG_W-1:0]              cfg;
        logic [DATA_W-1:0]             rdata;
    } st_t;

    st_t st_d, st_q;
    logic [BLK_W-1:0] blk;
    logic [2:0]       off;

    assign blk = addr[ADDR_W-1:3];
    assign off = addr[2:0];

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (wr_en && blk == BLK_W'(c)) begin
                case (off)
                    3'd0: st_d.t_sh[c] = wdata;
                    3'd1: st_d.t_sl[c] = wdata;
                    3'd2: st_d.t_nh[c] = wdata[NSH_W-1:0];
                    3'd3: st_d.t_nl[c] = wdata;
                    3'd4: st_d.p_sh[c] = wdata;
                    3'd5: st_d.p_sl[c] = wdata;
                    3'd6: st_d.p_nh[c] = wdata[NSH_W-1:0];
                    default: st_d.p_nl[c] = wdata;
                endcase
            end
            if (blk == BLK_W'(c)) begin
                case (off)
                    3'd0: st_d.rdata = st_q.t_sh[c];
                    3'd1: st_d.rdata = st_q.t_sl[c];
                    3'd2: st_d.rdata = DATA_W'(st_q.t_nh[c]);
                    3'd3: st_d.rdata = st_q.t_nl[c];
                    3'd4: st_d.rdata = st_q.p_sh[c];
                    3'd5: st_d.rdata = st_q.p_sl[c];
                    3'd6: st_d.rdata = DATA_W'(st_q.p_nh[c]);
                    default: st_d.rdata = st_q.p_nl[c];
                endcase
            end
        end
        if (wr_en && addr == CFG_ADDR)
            st_d.cfg = wdata[CFG_W-1:0];
        if (addr == CFG_ADDR)
            st_d.rdata = DATA_W'(st_q.cfg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            ld_stb[c]     = wr_en && (addr == ADDR_W'(c*8 + 2));
            ld_tgt[c].sec = {st_q.t_sh[c], st_q.t_sl[c]};
            ld_tgt[c].ns  = {wdata[NSH_W-1:0], st_q.t_nl[c]};
            period[c].sec = {st_q.p_sh[c], st_q.p_sl[c]};
            period[c].ns  = {st_q.p_nh[c], st_q.p_nl[c]};
            oneshot[c]    = st_q.cfg[2*c];
            pol[c]        = st_q.cfg[2*c+1];
            wcode[c]      = st_q.cfg[2*NUM_CH + WCODE_W*c +: WCODE_W];
        end
    end

    assign rdata = st_q.rdata;

    // R10: a configuration write is visible on the next cycle
    a_r10_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CFG_ADDR) |=> (st_q.cfg == $past(wdata[CFG_W-1:0])));

    // R2: read data follows the address by exactly one cycle for config
    a_r2_cfg_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == CFG_ADDR && !wr_en) |=> (rdata == DATA_W'($past(st_q.cfg))));
endmodule

// File: rtl/tpg_chan.sv
module tpg_chan
    import tpg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  tod_t               tod,
    input  logic               ld_stb,
    input  tod_t               ld_tgt,
    input  tod_t               period,
    input  logic [WCODE_W-1:0] wcode,
    input  logic               pol,
    input  logic               oneshot,
    output logic               pulse_o
);
    typedef struct packed {
        tod_t tgt;
        tod_t fin;
        logic armed;
        logic active;
    } st_t;

    st_t  st_d, st_q;
    tod_t nxt_tgt, fin_t, wtod;
    logic hit;

    always_comb begin
        wtod.sec = '0;
        wtod.ns  = width_ns(wcode);
    end

    tpg_time_add u_reload (.a(st_q.tgt), .b(period), .sum(nxt_tgt));
    tpg_time_add u_finish (.a(st_q.tgt), .b(wtod),   .sum(fin_t));

    always_comb begin
        st_d = st_q;
        hit  = st_q.armed && (tod >= st_q.tgt);
        if (st_q.active && (tod >= st_q.fin))
            st_d.active = 1'b0;
        if (hit) begin
            st_d.active = 1'b1;
            st_d.fin    = fin_t;
            if (oneshot) st_d.armed = 1'b0;
            else         st_d.tgt   = nxt_tgt;
        end
        if (ld_stb) begin
            st_d.tgt   = ld_tgt;
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = pol ? st_q.active : ~st_q.active;

    // R4: a pulse only starts from an armed channel whose target was reached
    a_r4_start_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> ($past(st_q.armed) && $past(tod >= st_q.tgt)));

    // R8: a one-shot match leaves the channel disarmed
    a_r8_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && oneshot && !ld_stb) |=> !st_q.armed);

    // R3: loading arms the channel with exactly the presented target
    a_r3_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |=> (st_q.armed && st_q.tgt == $past(ld_tgt)));

    // R5: a pulse past its end without a new match drops
    a_r5_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && tod >= st_q.fin && !hit) |=> !st_q.active);

    // R7: a periodic match keeps the channel armed
    a_r7_stay_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !oneshot) |=> st_q.armed);
endmodule

// File: rtl/tod_pulse_gen.sv
module tod_pulse_gen
    import tpg_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       tod_sec,
    input  logic [29:0]       tod_ns,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pulse_out
);
    tod_t                           tod;
    logic [NUM_CH-1:0]              ld_stb;
    tod_t [NUM_CH-1:0]              ld_tgt;
    tod_t [NUM_CH-1:0]              period;
    logic [NUM_CH-1:0][WCODE_W-1:0] wcode;
    logic [NUM_CH-1:0]              pol;
    logic [NUM_CH-1:0]              oneshot;

    assign tod.sec = tod_sec;
    assign tod.ns  = tod_ns;

    tpg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ld_stb(ld_stb), .ld_tgt(ld_tgt), .period(period),
        .wcode(wcode), .pol(pol), .oneshot(oneshot)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tpg_chan u_chan (
            .clk(clk), .rst_n(rst_n), .tod(tod), .ld_stb(ld_stb[c]),
            .ld_tgt(ld_tgt[c]), .period(period[c]), .wcode(wcode[c]),
            .pol(pol[c]), .oneshot(oneshot[c]), .pulse_o(pulse_out[c])
        );
    end
endmodule

// File: tb/sim_tod_pulse_gen.sv
module sim_tod_pulse_gen;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  code;
        logic [31:0] w;
    } vec_t;

    localparam vec_t VEC [16] = '{
        '{4'd0, 32'd100},       '{4'd1, 32'd500},        '{4'd2, 32'd1000},
        '{4'd3, 32'd5000},      '{4'd4, 32'd10000},      '{4'd5, 32'd50000},
        '{4'd6, 32'd100000},    '{4'd7, 32'd500000},     '{4'd8, 32'd1000000},
        '{4'd9, 32'd5000000},   '{4'd10, 32'd10000000},  '{4'd11, 32'd50000000},
        '{4'd12, 32'd100000000},'{4'd13, 32'd200000000}, '{4'd14, 32'd100},
        '{4'd15, 32'd100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tod_sec = '0;
    logic [29:0] tod_ns = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  pulse_out;

    int  checks = 0;
    int  errs = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_pulse_gen u0 (
        .clk(clk), .rst_n(rst_n), .tod_sec(tod_sec), .tod_ns(tod_ns),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .pulse_out(pulse_out)
    );

    function automatic logic [61:0] mk(input longint s, input longint n);
        return {32'(s), 30'(n)};
    endfunction

    function automatic logic [61:0] tadd(input logic [61:0] t, input longint dns);
        longint s = longint'(t[61:30]);
        longint n = longint'(t[29:0]) + dns;
        while (n >= 1000000000) begin
            n = n - 1000000000;
            s = s + 1;
        end
        return mk(s, n);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        @(posedge clk);
        #1;
        chk(tag, 32'(rdata), 32'(exp));
    endtask

    task automatic set_tod(input logic [61:0] t);
        @(negedge clk);
        tod_sec = t[61:30];
        tod_ns  = t[29:0];
        @(posedge clk);
        #1;
    endtask

    task automatic wr_target(input int base, input logic [61:0] t);
        logic [29:0] n = t[29:0];
        wr(5'(base + 0), t[61:46]);
        wr(5'(base + 1), t[45:30]);
        wr(5'(base + 3), n[15:0]);
        wr(5'(base + 2), {2'b00, n[29:16]});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [61:0] t;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 idle outputs", 32'(pulse_out), 32'h3);
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk(5'd16, 16'h0, "R1 cfg reads zero");
        rd_chk(5'd9, 16'h0, "R1 target reads zero");

        // R5 R6 R8 R4: width table on channel 0, one-shot, active high
        for (int i = 0; i < 16; i++) begin
            t = mk(10 + 3*i, 999_999_900);
            wr(5'd16, {8'h00, VEC[i].code, 4'b0011});
            wr_target(0, t);
            set_tod(t);
            chk($sformatf("R4 code %0d fires at target", i), 32'(pulse_out[0]), 32'd1);
            set_tod(tadd(t, longint'(VEC[i].w) - 1));
            chk($sformatf("R5 code %0d still active", i), 32'(pulse_out[0]), 32'd1);
            set_tod(tadd(t, longint'(VEC[i].w)));
            chk($sformatf("R5 code %0d ended", i), 32'(pulse_out[0]), 32'd0);
            set_tod(tadd(t, 2_000_000_000));
            chk($sformatf("R8 code %0d no refire", i), 32'(pulse_out[0]), 32'd0);
        end

        // R2: readback masking
        wr(5'd16, 16'hFFFF);
        rd_chk(5'd16, 16'h0FFF, "R2 cfg upper bits dropped");
        wr(5'd8, 16'hFFFF);
        wr(5'd9, 16'hFFFF);
        wr(5'd11, 16'h0000);
        wr(5'd10, 16'hFFFF);
        rd_chk(5'd10, 16'h3FFF, "R2 ns-high bits 15:14 dropped");
        rd_chk(5'd8, 16'hFFFF, "R2 seconds-high readback");

        // R10: ch0 periodic active-high, ch1 one-shot active-low, both code 0
        wr(5'd16, 16'h0006);
        rd_chk(5'd16, 16'h0006, "R10 cfg layout readback");

        // R9: all-ones seconds target never reached
        set_tod(mk(100, 0));
        chk("R9 silent channel", 32'(pulse_out[1]), 32'd1);
        chk("R6 ch0 idle low", 32'(pulse_out[0]), 32'd0);

        // R3: staged words do not arm
        wr(5'd8, 16'h0000);
        wr(5'd9, 16'd5);
        wr(5'd11, 16'h0000);
        set_tod(mk(100, 1));
        chk("R3 partial write no match", 32'(pulse_out[1]), 32'd1);
        wr(5'd10, 16'h0000);
        @(posedge clk);
        #1;
        chk("R3 commit then match active low", 32'(pulse_out[1]), 32'd0);
        chk("R10 ch0 untouched", 32'(pulse_out[0]), 32'd0);
        set_tod(mk(100, 2));
        chk("R6 ch1 back to idle", 32'(pulse_out[1]), 32'd1);

        // R7: periodic reload with nanosecond carry on channel 0
        t = mk(200, 999_999_950);
        wr(5'd4, 16'h0);
        wr(5'd5, 16'h0);
        wr(5'd6, 16'h0);
        wr(5'd7, 16'd600);
        wr_target(0, t);
        set_tod(t);
        chk("R7 first pulse", 32'(pulse_out[0]), 32'd1);
        set_tod(tadd(t, 100));
        chk("R7 first pulse ends", 32'(pulse_out[0]), 32'd0);
        set_tod(tadd(t, 599));
        chk("R7 before reload target", 32'(pulse_out[0]), 32'd0);
        set_tod(tadd(t, 600));
        chk("R7 second pulse after carry", 32'(pulse_out[0]), 32'd1);
        set_tod(tadd(t, 700));
        chk("R7 second pulse ends", 32'(pulse_out[0]), 32'd0);
        set_tod(tadd(t, 1200));
        chk("R7 third pulse", 32'(pulse_out[0]), 32'd1);
        chk("R10 ch1 stays idle", 32'(pulse_out[1]), 32'd1);

        // R11: new target replaces the pending reload target
        wr_target(0, mk(300, 0));
        set_tod(mk(250, 0));
        chk("R11 old target dropped", 32'(pulse_out[0]), 32'd0);
        set_tod(mk(300, 0));
        chk("R11 new target fires", 32'(pulse_out[0]), 32'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule